// File: doc/BRIEF.md
# Dual-Core Word Exchange Mailbox

This block lets two processor cores that share one clock pass 24-bit words and a few signalling bits to each other. Each core owns one receive queue, ten words deep by default. There is no transmit buffer: when a core writes its data register, the word goes straight into the queue of the opposite core. A core can therefore send a whole block of words, and the receiver can take them all in one interrupt service call.

Alongside the words, each core drives a 4-bit flag field that the opposite core sees in its status register. Each core has one interrupt line. The line can be raised by the state of its receive queue, in either not-empty or fill-threshold mode, by any enabled incoming flag, or by both.

Each core has its own synchronous register port with four registers. A read returns its value one cycle after it is issued. Address 0 is the data register: a write transmits and a read pops. Address 1 is status, whose sticky bits are cleared by writing a 1 to them. Address 2 holds the outgoing flags. Address 3 is interrupt control.

Top module: `xchg_mailbox`

## Requirements
- R1: A write to address 0 on one side puts the low DATA_W bits of the write data into the other side's receive queue. A read of address 0 on that side returns the words in the order they were written.
- R2: A receive queue holds DEPTH words. A word sent while the destination queue is full is dropped, even if the destination pops in that same cycle. The sending side's sticky overflow bit (status bit 16) is then set. Writing status with bit 16 set clears it.
- R3: A data read from an empty queue returns the word last popped on that side and sets the sticky underflow bit (status bit 17). Writing status with bit 17 set clears it.
- R4: The status word holds the fill count in bits [3:0], not-empty in bit 8, full in bit 9, the 4 incoming flags in bits [15:12], and the bits named in R2 and R3. All other bits read 0.
- R5: A write to address 2 sets the writer's 4 outgoing flags to write-data bits [3:0]. The other side's status shows them from the next cycle on. A read of address 2 returns the writer's own outgoing flags.
- R6: The control register at address 3 holds: bit 0 receive-interrupt enable, bit 1 threshold mode, bits [7:4] flag-interrupt enables, bits [11:8] threshold. With bit 0 set, the interrupt is high while the queue is not empty (bit 1 = 0) or while the count is at least the threshold (bit 1 = 1). It falls as soon as reads drain the queue below that condition.
- R7: The interrupt is also high while any incoming flag bit is 1 and its enable bit in control bits [7:4] is 1. An incoming flag whose enable bit is 0 leaves the interrupt low.
- R8: Read data is registered and valid from the cycle after the read. A send into a side and a pop on that side in the same cycle both take effect, and the fill count stays the same.
- R9: After reset both queues are empty, all flags, sticky bits and control fields are 0, both interrupts are low, and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A register write strobe |
| a_rd | input | 1 | Side A register read strobe |
| a_addr | input | 2 | Side A register address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A registered read data |
| a_irq | output | 1 | Side A interrupt request |
| b_wr | input | 1 | Side B register write strobe |
| b_rd | input | 1 | Side B register read strobe |
| b_addr | input | 2 | Side B register address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B registered read data |
| b_irq | output | 1 | Side B interrupt request |

## Verification
The bench builds the block with its defaults: DATA_W 24, FLAG_W 4 and DEPTH 10. With ten slots, the full state, the dropped eleventh word and the overflow bit can be reached in a few dozen cycles, and every fill count fits in the 4-bit status field. The 4-bit flag width lets the bench check one masked and one unmasked flag interrupt. A threshold of 3 gives an interrupt that rises on the third queued word and falls on the first pop.

// File: rtl/xchg_mailbox.sv
module xchg_mailbox #(
  parameter int DATA_W = 24,
  parameter int FLAG_W = 4,
  parameter int DEPTH  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [1:0]        a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [1:0]        b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] AD_DATA = 2'd0, AD_STAT = 2'd1, AD_FLAG = 2'd2, AD_CTRL = 2'd3;
  localparam int ST_NE = 8, ST_FULL = 9, ST_FLG = 12, ST_OVF = 16, ST_UNF = 17;
  localparam int CT_RXIE = 0, CT_THR = 1, CT_FIE = 4, CT_LVL = 8;
  localparam logic [DATA_W-1:0] CTL_MASK =
      DATA_W'(3) | (DATA_W'((1 << FLAG_W) - 1) << CT_FIE) | (DATA_W'((1 << CNT_W) - 1) << CT_LVL);

  logic              wr [2], rd [2];
  logic [1:0]        ad [2];
  logic [DATA_W-1:0] wd [2], rq [2];

  logic [DATA_W-1:0] mem [2][DEPTH];
  logic [PTR_W-1:0]  rp [2], wp [2];
  logic [CNT_W-1:0]  cnt [2];
  logic [FLAG_W-1:0] flg [2];
  logic              ovf [2], unf [2];
  logic [DATA_W-1:0] last_rx [2], ctl [2];

  logic              empty [2], full [2], tx_try [2], rx_try [2], push [2], pop [2], rx_cond [2], irq [2];
  logic [DATA_W-1:0] stat [2];

  assign wr[0] = a_wr;    assign wr[1] = b_wr;
  assign rd[0] = a_rd;    assign rd[1] = b_rd;
  assign ad[0] = a_addr;  assign ad[1] = b_addr;
  assign wd[0] = a_wdata; assign wd[1] = b_wdata;
  assign a_rdata = rq[0]; assign b_rdata = rq[1];
  assign a_irq   = irq[0]; assign b_irq  = irq[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int O = 1 - s;
    assign empty[s]  = (cnt[s] == '0);
    assign full[s]   = (cnt[s] == CNT_W'(DEPTH));
    assign tx_try[s] = wr[s] && (ad[s] == AD_DATA);
    assign rx_try[s] = rd[s] && (ad[s] == AD_DATA);
    assign push[s]   = tx_try[O] && !full[s];
    assign pop[s]    = rx_try[s] && !empty[s];
    assign rx_cond[s] = ctl[s][CT_THR] ? (cnt[s] >= ctl[s][CT_LVL +: CNT_W]) : !empty[s];
    assign irq[s] = (ctl[s][CT_RXIE] && rx_cond[s]) || |(flg[O] & ctl[s][CT_FIE +: FLAG_W]);

    always_comb begin
      stat[s] = '0;
      stat[s][CNT_W-1:0]         = cnt[s];
      stat[s][ST_NE]             = !empty[s];
      stat[s][ST_FULL]           = full[s];
      stat[s][ST_FLG +: FLAG_W]  = flg[O];
      stat[s][ST_OVF]            = ovf[s];
      stat[s][ST_UNF]            = unf[s];
    end

    always_ff @(posedge clk) begin
      if (push[s]) mem[s][wp[s]] <= wd[O];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp[s] <= '0; wp[s] <= '0; cnt[s] <= '0; flg[s] <= '0;
        ovf[s] <= 1'b0; unf[s] <= 1'b0;
        last_rx[s] <= '0; ctl[s] <= '0; rq[s] <= '0;
      end else begin
        if (push[s]) wp[s] <= (wp[s] == PTR_W'(DEPTH - 1)) ? '0 : wp[s] + 1'b1;
        if (pop[s])  rp[s] <= (rp[s] == PTR_W'(DEPTH - 1)) ? '0 : rp[s] + 1'b1;
        cnt[s] <= cnt[s] + CNT_W'(push[s]) - CNT_W'(pop[s]);
        if (wr[s]) begin
          case (ad[s])
            AD_DATA: if (full[O]) ovf[s] <= 1'b1;
            AD_STAT: begin
              if (wd[s][ST_OVF]) ovf[s] <= 1'b0;
              if (wd[s][ST_UNF]) unf[s] <= 1'b0;
            end
            AD_FLAG: flg[s] <= wd[s][FLAG_W-1:0];
            default: ctl[s] <= wd[s] & CTL_MASK;
          endcase
        end
        if (rd[s]) begin
          case (ad[s])
            AD_DATA: begin
              if (pop[s]) begin
                rq[s] <= mem[s][rp[s]];
                last_rx[s] <= mem[s][rp[s]];
              end else begin
                rq[s] <= last_rx[s];
                unf[s] <= 1'b1;
              end
            end
            AD_STAT: rq[s] <= stat[s];
            AD_FLAG: rq[s] <= DATA_W'(flg[s]);
            default: rq[s] <= ctl[s];
          endcase
        end
      end
    end

    assert_fifo_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[s] <= CNT_W'(DEPTH));
    assert_drop_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_try[O] && full[s] && !rx_try[s]) |=> (cnt[s] == $past(cnt[s])));
    assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_try[s] && full[O]) |=> ovf[s]);
    assert_underflow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_try[s] && empty[s]) |=> (unf[s] && rq[s] == $past(last_rx[s])));
    assert_flag_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr[O] && ad[O] == AD_FLAG) |=> (stat[s][ST_FLG +: FLAG_W] == $past(wd[O][FLAG_W-1:0])));
    assert_pushpop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push[s] && pop[s]) |=> $stable(cnt[s]));
    assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty[s] && !ctl[s][CT_THR] && ctl[s][CT_FIE +: FLAG_W] == '0) |-> !irq[s]);
  end
endmodule

// File: tb/test_xchg_mailbox.sv
module test_xchg_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [1:0] a_addr = 0, b_addr = 0;
  logic [23:0] a_wdata = 0, b_wdata = 0;
  logic [23:0] a_rdata, b_rdata;
  logic a_irq, b_irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  xchg_mailbox i_xchg_mailbox (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // entry: {side(0=A,1=B), is_read, addr, data, expected}
  localparam logic [51:0] VEC [11] = '{
    {1'b0, 1'b0, 2'd0, 24'h111111, 24'h0},
    {1'b0, 1'b0, 2'd0, 24'h222222, 24'h0},
    {1'b0, 1'b0, 2'd0, 24'h333333, 24'h0},
    {1'b1, 1'b1, 2'd1, 24'h0, 24'h000103},
    {1'b1, 1'b1, 2'd0, 24'h0, 24'h111111},
    {1'b1, 1'b1, 2'd0, 24'h0, 24'h222222},
    {1'b1, 1'b1, 2'd0, 24'h0, 24'h333333},
    {1'b1, 1'b0, 2'd0, 24'hABCDEF, 24'h0},
    {1'b0, 1'b1, 2'd1, 24'h0, 24'h000101},
    {1'b0, 1'b1, 2'd0, 24'h0, 24'hABCDEF},
    {1'b1, 1'b1, 2'd1, 24'h0, 24'h000000}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input bit side, input logic [1:0] ad, input logic [23:0] d);
    @(negedge clk);
    if (side) begin b_wr = 1; b_addr = ad; b_wdata = d; end
    else      begin a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic do_rd(input bit side, input logic [1:0] ad, output logic [23:0] v);
    @(negedge clk);
    if (side) begin b_rd = 1; b_addr = ad; end
    else      begin a_rd = 1; a_addr = ad; end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
    v = side ? b_rdata : a_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 a_irq", 24'(a_irq), 24'h0);
    chk("R9 b_irq", 24'(b_irq), 24'h0);
    chk("R9 a_rdata", a_rdata, 24'h0);
    do_rd(0, 2'd1, v); chk("R9 A status", v, 24'h0);
    do_rd(1, 2'd3, v); chk("R9 B ctrl", v, 24'h0);

    // R1 R4 table walk
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][50]) begin
        do_rd(VEC[i][51], VEC[i][49:48], v);
        chk($sformatf("R1 R4 vec %0d", i), v, VEC[i][23:0]);
      end else begin
        do_wr(VEC[i][51], VEC[i][49:48], VEC[i][47:24]);
      end
    end

    // R2 fill, drop, overflow
    for (int i = 0; i < 10; i++) do_wr(0, 2'd0, 24'h000100 + 24'(i));
    do_rd(1, 2'd1, v); chk("R2 R4 full status", v, 24'h00030A);
    do_wr(0, 2'd0, 24'hDEAD00);
    do_rd(0, 2'd1, v); chk("R2 overflow sticky", v, 24'h010000);
    do_rd(1, 2'd1, v); chk("R2 count unchanged", v, 24'h00030A);
    for (int i = 0; i < 10; i++) begin
      do_rd(1, 2'd0, v); chk("R2 drain order", v, 24'h000100 + 24'(i));
    end
    do_wr(0, 2'd1, 24'h010000);
    do_rd(0, 2'd1, v); chk("R2 overflow cleared", v, 24'h0);

    // R3 underflow
    do_rd(1, 2'd0, v); chk("R3 empty read repeats", v, 24'h000109);
    do_rd(1, 2'd1, v); chk("R3 underflow sticky", v, 24'h020000);
    do_wr(1, 2'd1, 24'h020000);
    do_rd(1, 2'd1, v); chk("R3 underflow cleared", v, 24'h0);

    // R5 flags
    do_wr(0, 2'd2, 24'hFFFFF5);
    do_rd(1, 2'd1, v); chk("R5 flags at peer", v, 24'h005000);
    do_rd(0, 2'd2, v); chk("R5 own flags readback", v, 24'h000005);

    // R7 flag interrupt with mask
    do_wr(1, 2'd3, 24'h000010);
    chk("R7 enabled flag irq", 24'(b_irq), 24'h1);
    do_wr(0, 2'd2, 24'h000004);
    chk("R7 masked flag no irq", 24'(b_irq), 24'h0);
    do_wr(1, 2'd3, 24'h000040);
    chk("R7 flag2 enabled irq", 24'(b_irq), 24'h1);
    do_wr(1, 2'd3, 24'h0);
    chk("R7 disabled", 24'(b_irq), 24'h0);

    // R6 not-empty mode
    do_wr(0, 2'd3, 24'h000001);
    chk("R6 empty no irq", 24'(a_irq), 24'h0);
    do_wr(1, 2'd0, 24'h00AAAA);
    chk("R6 not-empty irq", 24'(a_irq), 24'h1);
    do_rd(0, 2'd0, v);
    chk("R6 drained irq low", 24'(a_irq), 24'h0);

    // R6 threshold mode, level 3
    do_wr(0, 2'd3, 24'hFFF303);
    do_rd(0, 2'd3, v); chk("R6 ctrl readback", v, 24'h000303);
    do_wr(1, 2'd0, 24'h000001);
    do_wr(1, 2'd0, 24'h000002);
    chk("R6 below threshold", 24'(a_irq), 24'h0);
    do_wr(1, 2'd0, 24'h000003);
    chk("R6 at threshold", 24'(a_irq), 24'h1);
    do_rd(0, 2'd0, v); chk("R1 first out", v, 24'h000001);
    chk("R6 drained below threshold", 24'(a_irq), 24'h0);
    do_rd(0, 2'd0, v);
    do_rd(0, 2'd0, v); chk("R1 last out", v, 24'h000003);

    // R8 simultaneous push and pop
    do_wr(1, 2'd0, 24'h000777);
    @(negedge clk);
    a_rd = 1; a_addr = 2'd0; b_wr = 1; b_addr = 2'd0; b_wdata = 24'h000888;
    @(negedge clk);
    a_rd = 0; b_wr = 0;
    chk("R8 pop during push", a_rdata, 24'h000777);
    do_rd(0, 2'd1, v); chk("R8 count held", v, 24'h000101);
    do_rd(0, 2'd0, v); chk("R8 pushed word", v, 24'h000888);

    finish_run();
  end
endmodule